// File: doc/BRIEF.md
# Store Buffer with Newest-Match Load Forwarding

This block holds stores that the pipeline has committed but the data cache has not yet taken. Stores enter at the write pointer of a circular queue. The oldest store stays on a drain port under a valid/ready handshake until the cache takes it. The occupancy flags let the pipeline stall pushes when the queue is full and stop draining when it is empty.

Every load presented on the lookup port is compared in parallel against all occupied entries. A hit needs two things: the full address must be equal, and the access size must be identical. When several entries qualify, the most recently pushed one supplies the data, so the load never sees a value older than program order allows. The forwarding result is registered and appears one cycle after the lookup. It is judged against the queue contents as they stood before that clock edge.

Top module: `stbuf_fwd`

## Requirements
- R1: While `rst` is sampled high, the block clears itself. One cycle after release, `empty`=1, `full`=0, `drain_valid`=0 and `fwd_hit`=0.
- R2: Stores accepted at the push port leave the drain port in the order they were pushed. Address, data and size are unchanged.
- R3: `full` is 1 exactly when DEPTH stores are held. A push while `full` is 1 is dropped and leaves the held contents unchanged.
- R4: `drain_valid` is 1 exactly when the queue is not empty. The head entry is removed only in a cycle with `drain_valid` and `drain_ready` both 1, and it stays stable otherwise.
- R5: A push and a drain in the same cycle are both taken, and the occupancy is unchanged.
- R6: A lookup with `ld_valid`=1 hits when an occupied entry has an equal address and an equal size. `fwd_hit` and `fwd_data` show the result in the following cycle.
- R7: Sizes are coded 0=byte, 1=halfword, 2=word. An entry whose address matches but whose size differs does not hit.
- R8: When several occupied entries match, `fwd_data` is the data of the newest one.
- R9: With `ld_valid`=0 or no match, `fwd_hit` is 0 and `fwd_data` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Store to enqueue this cycle |
| push_addr | input | AW | Store address |
| push_data | input | DW | Store data |
| push_size | input | 2 | Store size code |
| full | output | 1 | Queue holds DEPTH stores |
| empty | output | 1 | Queue holds no store |
| drain_valid | output | 1 | Head store offered to cache |
| drain_ready | input | 1 | Cache takes head store |
| drain_addr | output | AW | Head store address |
| drain_data | output | DW | Head store data |
| drain_size | output | 2 | Head store size code |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_addr | input | AW | Load address |
| ld_size | input | 2 | Load size code |
| fwd_hit | output | 1 | Registered forwarding hit |
| fwd_data | output | DW | Registered forwarded data |

## Verification
Two pairs of operations can fall in the same cycle. One pair is an enqueue together with a drain handshake, including at full occupancy. The other is a lookup together with the removal of the entry it would match. Both are provoked by directed sequences: fill the queue and then push and drain together, and look up the address of the head store in the cycle it leaves. Random traffic over a pool of four addresses then provokes both pairs many more times. A queue model in the bench predicts the flags, the head entry and the forwarded value from the contents before each edge, so the bench can tell whether the design took both operations.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef logic [1:0] acc_size_t;
  localparam acc_size_t SZ_BYTE = 2'd0;
  localparam acc_size_t SZ_HALF = 2'd1;
  localparam acc_size_t SZ_WORD = 2'd2;
endpackage

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    rd_ptr,
  output logic             full,
  output logic             empty,
  output logic [DEPTH-1:0] valid_mask
);
  logic [CW-1:0] cnt_q, cnt_n;

  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  always_comb begin
    cnt_n = cnt_q;
    if (push_ok && !pop_ok)      cnt_n = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      full  <= (cnt_n == CW'(DEPTH));
      empty <= (cnt_n == '0);
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // Entry i is occupied when its age relative to the head is below the count.
  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    logic [PW-1:0] age;
    assign age           = PW'(i) - rd_ptr;
    assign valid_mask[i] = ({1'b0, age} < cnt_q);
  end
endmodule

// File: rtl/stbuf_store.sv
module stbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [PW-1:0]             waddr,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  stbuf_pkg::acc_size_t      wr_size,
  output logic [DEPTH-1:0][AW-1:0]  addr_arr,
  output logic [DEPTH-1:0][DW-1:0]  data_arr,
  output logic [DEPTH-1:0][1:0]     size_arr
);
  // Register array: every entry must be visible at once for the parallel search.
  always_ff @(posedge clk) begin
    if (we) begin
      addr_arr[waddr] <= wr_addr;
      data_arr[waddr] <= wr_data;
      size_arr[waddr] <= wr_size;
    end
  end
endmodule

// File: rtl/stbuf_match.sv
module stbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]             ld_addr,
  input  stbuf_pkg::acc_size_t      ld_size,
  input  logic [PW-1:0]             rd_ptr,
  input  logic [DEPTH-1:0]          valid_mask,
  input  logic [DEPTH-1:0][AW-1:0]  addr_arr,
  input  logic [DEPTH-1:0][DW-1:0]  data_arr,
  input  logic [DEPTH-1:0][1:0]     size_arr,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = valid_mask[i] && (addr_arr[i] == ld_addr) && (size_arr[i] == ld_size);
  end

  // Scan from oldest to newest; a later (younger) match overrides an earlier one.
  always_comb begin
    logic [PW-1:0] idx;
    hit      = 1'b0;
    hit_data = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_ptr + PW'(k);
      if (match[idx]) begin
        hit      = 1'b1;
        hit_data = data_arr[idx];
      end
    end
  end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [1:0]    push_size,
  output logic          full,
  output logic          empty,
  output logic          drain_valid,
  input  logic          drain_ready,
  output logic [AW-1:0] drain_addr,
  output logic [DW-1:0] drain_data,
  output logic [1:0]    drain_size,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data
);
  logic                     push_ok, pop_ok;
  logic [PW-1:0]            wr_ptr, rd_ptr;
  logic [DEPTH-1:0]         valid_mask;
  logic [DEPTH-1:0][AW-1:0] addr_arr;
  logic [DEPTH-1:0][DW-1:0] data_arr;
  logic [DEPTH-1:0][1:0]    size_arr;
  logic                     hit;
  logic [DW-1:0]            hit_data;

  stbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(push_valid), .pop_req(drain_ready),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty), .valid_mask(valid_mask)
  );

  stbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wr_addr(push_addr),
    .wr_data(push_data), .wr_size(push_size),
    .addr_arr(addr_arr), .data_arr(data_arr), .size_arr(size_arr)
  );

  stbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .ld_addr(ld_addr), .ld_size(ld_size), .rd_ptr(rd_ptr),
    .valid_mask(valid_mask), .addr_arr(addr_arr), .data_arr(data_arr),
    .size_arr(size_arr), .hit(hit), .hit_data(hit_data)
  );

  assign drain_valid = !empty;
  assign drain_addr  = addr_arr[rd_ptr];
  assign drain_data  = data_arr[rd_ptr];
  assign drain_size  = size_arr[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= ld_valid && hit;
      fwd_data <= (ld_valid && hit) ? hit_data : '0;
    end
  end
endmodule

// File: rtl/stbuf_fwd_chk.sv
module stbuf_fwd_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          push_valid,
  input logic          full,
  input logic          empty,
  input logic          drain_valid,
  input logic          drain_ready,
  input logic [AW-1:0] drain_addr,
  input logic [DW-1:0] drain_data,
  input logic          ld_valid,
  input logic          fwd_hit,
  input logic [DW-1:0] fwd_data
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (empty && !full && !fwd_hit));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_stay_full_R3: assert property (@(posedge clk) disable iff (rst)
    (full && !drain_ready) |=> full);

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_addr) && $stable(drain_data)));

  assert_pushpop_level_R5: assert property (@(posedge clk) disable iff (rst)
    (drain_valid && drain_ready && push_valid && !full) |=> ($stable(full) && $stable(empty)));

  assert_idle_lookup_R9: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!fwd_hit && fwd_data == '0));

  assert_empty_lookup_R9: assert property (@(posedge clk) disable iff (rst)
    empty |=> !fwd_hit);
endmodule

bind stbuf_fwd stbuf_fwd_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid), .full(full), .empty(empty),
  .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_addr(drain_addr),
  .drain_data(drain_data), .ld_valid(ld_valid), .fwd_hit(fwd_hit), .fwd_data(fwd_data)
);

// File: tb/stbuf_fwd_test.sv
`timescale 1ns/1ps
module stbuf_fwd_test;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0, drain_ready = 1'b0, ld_valid = 1'b0;
  logic [AW-1:0] push_addr = '0, ld_addr = '0;
  logic [DW-1:0] push_data = '0;
  logic [1:0] push_size = '0, ld_size = '0;
  logic full, empty, drain_valid, fwd_hit;
  logic [AW-1:0] drain_addr;
  logic [DW-1:0] drain_data, fwd_data;
  logic [1:0] drain_size;

  always #4 clk = ~clk;

  stbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (.*);

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [1:0] s; } ent_t;
  ent_t mq[$];

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  bit exp_hit = 0;
  logic [DW-1:0] exp_data = '0;
  string fwd_tag = "R9", lvl_tag = "R4";

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench reference for a lookup against the model contents before the edge.
  function automatic void predict(bit lv, logic [AW-1:0] la, logic [1:0] ls);
    int nm = 0;
    bit szm = 0;
    exp_hit = 0; exp_data = '0;
    if (lv) foreach (mq[i]) if (mq[i].a == la) begin
      if (mq[i].s == ls) begin exp_hit = 1; exp_data = mq[i].d; nm++; end
      else szm = 1;
    end
    if (!lv) fwd_tag = "R9 idle";
    else if (nm > 1) fwd_tag = "R8 newest";
    else if (szm && !exp_hit) fwd_tag = "R7 size";
    else if (exp_hit) fwd_tag = "R6 hit";
    else fwd_tag = "R9 miss";
  endfunction

  task automatic step(bit pv, logic [AW-1:0] pa, logic [DW-1:0] pd, logic [1:0] ps,
                      bit dr, bit lv, logic [AW-1:0] la, logic [1:0] ls);
    bit fpre, popping, pushing;
    chk({lvl_tag, " empty"}, DW'(empty), DW'(mq.size() == 0));
    chk({lvl_tag, " full"}, DW'(full), DW'(mq.size() == DEPTH));
    chk("R4 drain_valid", DW'(drain_valid), DW'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R2 drain_addr", drain_addr, mq[0].a);
      chk("R2 drain_data", drain_data, mq[0].d);
      chk("R2 drain_size", DW'(drain_size), DW'(mq[0].s));
    end
    chk({fwd_tag, " fwd_hit"}, DW'(fwd_hit), DW'(exp_hit));
    chk({fwd_tag, " fwd_data"}, fwd_data, exp_data);
    push_valid = pv; push_addr = pa; push_data = pd; push_size = ps;
    drain_ready = dr; ld_valid = lv; ld_addr = la; ld_size = ls;
    predict(lv, la, ls);
    fpre = (mq.size() == DEPTH);
    popping = dr && mq.size() != 0;
    pushing = pv && !fpre;
    lvl_tag = (pv && fpre && !popping) ? "R3" : (pushing && popping) ? "R5" : "R4";
    if (popping) void'(mq.pop_front());
    if (pushing) mq.push_back('{pa, pd, ps});
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] pool(int k);
    return 32'h100 + AW'(k % 4) * 32'h40;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 empty", DW'(empty), 1);
    chk("R1 full", DW'(full), 0);
    chk("R1 drain_valid", DW'(drain_valid), 0);
    chk("R1 fwd_hit", DW'(fwd_hit), 0);

    // Fill to DEPTH, looking up the previous store each time.
    for (int i = 0; i < DEPTH; i++)
      step(1, pool(i), 32'hA0 + i, 2, 0, 1, pool(i - 1), 2);
    // Push while full must be dropped (R3).
    step(1, 32'h900, 32'hDEAD, 2, 0, 1, 32'h900, 2);
    step(0, 0, 0, 0, 0, 1, 32'h900, 2);
    // Push and drain together at full, lookup on the leaving head (R5).
    step(1, 32'h500, 32'hB1, 1, 1, 1, pool(0), 2);
    step(1, 32'h504, 32'hB2, 0, 1, 1, 32'h500, 1);
    // Drain while stalled then empty out (R4).
    step(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    // Same address, several stores: newest wins (R8), size mismatch misses (R7).
    step(1, 32'h40, 32'h11, 2, 0, 0, 0, 0);
    step(1, 32'h40, 32'h22, 2, 0, 1, 32'h40, 2);
    step(1, 32'h40, 32'h33, 1, 0, 1, 32'h40, 2);
    step(0, 0, 0, 0, 0, 1, 32'h40, 0);
    step(0, 0, 0, 0, 0, 1, 32'h40, 1);
    step(0, 0, 0, 0, 0, 1, 32'h40, 2);
    step(0, 0, 0, 0, 0, 0, 32'h40, 2);

    // Constrained random traffic over a small address pool.
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      step(r[0], pool($urandom % 4), $urandom, 2'($urandom % 3),
           r[1] | r[2], r[3] | r[4], pool($urandom % 4), 2'($urandom % 3));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule